// File: doc/BRIEF.md
# Descriptor Table Register Store Unit

This unit carries out the store of the interrupt descriptor table register into memory for a simplified processor pipeline. Each cycle it may be handed one decoded instruction together with the processor's current mode, privilege level, the user-mode instruction prevention control bit, the alignment-check enable, the effective address and the canonical-form and segment checks worked out elsewhere. If the instruction is not the descriptor-table store it is ignored. Otherwise the unit looks for faults in a fixed priority order and either reports a single exception vector or issues one byte-enabled write that holds the 16-bit table limit and the table base.

Outside 64-bit mode the write is a 6-byte image. In 64-bit mode it is a 10-byte image. A write request stays up until the memory side accepts it, and a completion pulse follows one cycle later. A fault replaces the write with a one-cycle fault pulse. Address generation, segmentation and paging are done outside this unit, and a page fault reported by them is only passed through. The unit has no flag outputs, so the arithmetic flags are never touched.

Top module: `dtr_store_unit`

## Requirements
- R1: An instruction is taken only when the first opcode byte is 0x0F, the second is 0x01, ModRM bits 5:3 equal 1 and ModRM bits 7:6 are not 2'b11. Any other instruction produces neither a write nor a fault.
- R2: Outside 64-bit mode (mode codes 0 real, 1 virtual-8086, 2 protected/compatibility), the write has byte enables 0x003F. Data bits 15:0 hold the limit, bits 47:16 hold base bits 31:0, and every other data bit is zero.
- R3: In 64-bit mode (mode code 3), the write has byte enables 0x03FF. Data bits 15:0 hold the limit and bits 79:16 hold the full 64-bit base. The write address equals the effective address in every mode.
- R4: A LOCK prefix gives vector 6 (#UD) in every mode, and no write is issued.
- R5: With the prevention bit set, the unit gives vector 13 (#GP) in protected and 64-bit modes when the privilege level is above 0, and in virtual-8086 mode at any privilege level. Real mode never raises this fault.
- R6: Vector 17 (#AC) is raised when alignment checking is enabled and the address is misaligned (bit 0 set for the 6-byte form, any of bits 2:0 set for the 10-byte form). This needs privilege level 3 in protected and 64-bit modes, applies at any level in virtual-8086 mode, and never applies in real mode.
- R7: In 64-bit mode a non-canonical address gives vector 12 (#SS) when the access uses the stack segment and vector 13 otherwise. Segment-limit and null-selector inputs are ignored in this mode.
- R8: Outside 64-bit mode a segment-limit violation gives vector 12 for stack-segment accesses and 13 for the others. A null data-segment selector gives 13 only in protected mode.
- R9: When several faults apply, only the highest is reported. The order is LOCK, then prevention, then segment/canonical, then alignment, then page fault.
- R10: A write request holds its address, data and enables stable until the accept input is seen. The done output pulses for one cycle in the cycle after acceptance. A fault is a one-cycle pulse of the fault output with the vector, and it never overlaps a write or done.
- R11: An external page-fault indication gives vector 14 (#PF) in every mode except real mode, where it is ignored.
- R12: After reset the write request, done and fault outputs are low, and the fault vector is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Decoded instruction present (taken only when idle) |
| opc_b0 | input | 8 | First opcode byte |
| opc_b1 | input | 8 | Second opcode byte |
| modrm | input | 8 | ModRM byte |
| lock_pfx | input | 1 | LOCK prefix present |
| cpu_mode | input | 2 | 0 real, 1 virtual-8086, 2 protected/compat, 3 64-bit |
| cpl | input | 2 | Current privilege level |
| umip_en | input | 1 | User-mode instruction prevention bit |
| ac_en | input | 1 | Alignment checking enabled |
| eff_addr | input | 64 | Effective address of the destination |
| addr_canon | input | 1 | Address is canonical (64-bit mode) |
| seg_lim_ok | input | 1 | Access within segment limit |
| seg_is_ss | input | 1 | Access uses the stack segment |
| seg_null | input | 1 | Data segment selector is NULL |
| pg_fault | input | 1 | Page fault reported by translation |
| tbl_limit | input | 16 | Current table limit |
| tbl_base | input | 64 | Current table base |
| wr_valid | output | 1 | Memory write request |
| wr_ready | input | 1 | Memory write accepted |
| wr_addr | output | 64 | Write address |
| wr_data | output | 128 | Write data, byte 0 in bits 7:0 |
| wr_be | output | 16 | Per-byte write enables |
| done | output | 1 | Store completed |
| fault_valid | output | 1 | Fault reported |
| fault_vec | output | 8 | Exception vector of the fault |

## Verification
The hardest cases to reach are the priority collisions, where two or more fault conditions hold at once and only the top one may show. One example is a stack-segment limit violation together with a misaligned user-level access. Another is an alignment fault together with a pending page fault. The directed tasks set these conflicting inputs up on purpose. They also drive the mode-dependent exemptions: real mode with the prevention bit set, and virtual-8086 mode at privilege 0 with a misaligned address. Each write is held unaccepted for one extra cycle before the accept is given, so that the stability rule is exercised.

// File: rtl/dtr_store_pkg.sv
package dtr_store_pkg;

   typedef enum logic [1:0] {
      MODE_REAL = 2'd0,
      MODE_V86  = 2'd1,
      MODE_PROT = 2'd2,
      MODE_LONG = 2'd3
   } cpu_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WRITE = 2'd1,
      ST_FIN   = 2'd2,
      ST_FLT   = 2'd3
   } store_st_e;

   localparam logic [7:0] VEC_UD = 8'd6;
   localparam logic [7:0] VEC_SS = 8'd12;
   localparam logic [7:0] VEC_GP = 8'd13;
   localparam logic [7:0] VEC_PF = 8'd14;
   localparam logic [7:0] VEC_AC = 8'd17;

endpackage

// File: rtl/dtr_decode.sv
module dtr_decode #(
   parameter logic [7:0] OPC_ESC = 8'h0F,
   parameter logic [7:0] OPC_GRP = 8'h01,
   parameter logic [2:0] REG_SEL = 3'd1
) (
   input  logic [7:0] opc_b0,
   input  logic [7:0] opc_b1,
   input  logic [7:0] modrm,
   output logic       hit
);
   logic opc_ok;
   logic reg_ok;
   logic mem_form;

   always_comb begin
      opc_ok   = (opc_b0 == OPC_ESC) && (opc_b1 == OPC_GRP);
      reg_ok   = (modrm[5:3] == REG_SEL);
      mem_form = (modrm[7:6] != 2'b11);
      hit      = opc_ok && reg_ok && mem_form;
   end
endmodule

// File: rtl/dtr_fault_check.sv
module dtr_fault_check
   import dtr_store_pkg::*;
#(
   parameter int SHORT_ALIGN = 2,
   parameter int LONG_ALIGN  = 8,
   localparam int LO_W       = (LONG_ALIGN > 1) ? $clog2(LONG_ALIGN) : 1
) (
   input  cpu_mode_e       mode,
   input  logic [1:0]      cpl,
   input  logic            umip_en,
   input  logic            ac_en,
   input  logic            lock_pfx,
   input  logic [LO_W-1:0] addr_lo,
   input  logic            addr_canon,
   input  logic            seg_lim_ok,
   input  logic            seg_is_ss,
   input  logic            seg_null,
   input  logic            pg_fault,
   output logic            flt,
   output logic [7:0]      vec
);
   localparam logic [LO_W-1:0] SHORT_MASK = LO_W'(SHORT_ALIGN - 1);
   localparam logic [LO_W-1:0] LONG_MASK  = LO_W'(LONG_ALIGN - 1);

   if ((SHORT_ALIGN & (SHORT_ALIGN - 1)) != 0 || (LONG_ALIGN & (LONG_ALIGN - 1)) != 0)
   begin : g_bad_align
      $error("alignment parameters must be powers of two");
   end
   if (SHORT_ALIGN > LONG_ALIGN) begin : g_bad_order
      $error("short alignment may not exceed long alignment");
   end

   logic       is64;
   logic       umip_hit;
   logic       seg_hit;
   logic [7:0] seg_vec;
   logic       misalign;
   logic       ac_hit;
   logic       pf_hit;

   always_comb begin
      is64 = (mode == MODE_LONG);

      unique case (mode)
         MODE_V86:            umip_hit = umip_en;
         MODE_PROT,
         MODE_LONG:           umip_hit = umip_en && (cpl != 2'd0);
         default:             umip_hit = 1'b0;
      endcase

      seg_hit = 1'b0;
      seg_vec = VEC_GP;
      if (is64) begin
         seg_hit = !addr_canon;
         seg_vec = seg_is_ss ? VEC_SS : VEC_GP;
      end else if (!seg_lim_ok) begin
         seg_hit = 1'b1;
         seg_vec = seg_is_ss ? VEC_SS : VEC_GP;
      end else if (mode == MODE_PROT && seg_null && !seg_is_ss) begin
         seg_hit = 1'b1;
         seg_vec = VEC_GP;
      end

      misalign = is64 ? |(addr_lo & LONG_MASK) : |(addr_lo & SHORT_MASK);
      unique case (mode)
         MODE_V86:            ac_hit = ac_en && misalign;
         MODE_PROT,
         MODE_LONG:           ac_hit = ac_en && misalign && (cpl == 2'd3);
         default:             ac_hit = 1'b0;
      endcase

      pf_hit = pg_fault && (mode != MODE_REAL);

      flt = 1'b1;
      if (lock_pfx)      vec = VEC_UD;
      else if (umip_hit) vec = VEC_GP;
      else if (seg_hit)  vec = seg_vec;
      else if (ac_hit)   vec = VEC_AC;
      else if (pf_hit)   vec = VEC_PF;
      else begin
         flt = 1'b0;
         vec = 8'd0;
      end
   end

   // R9: LOCK outranks every other fault source
   always_comb begin
      if (lock_pfx) begin
         a_r9_lock_first: assert (flt && vec == VEC_UD);
      end
   end

   // R5: real mode never reports the prevention fault ahead of lower checks
   always_comb begin
      if (mode == MODE_REAL && !lock_pfx && seg_lim_ok && !pg_fault) begin
         a_r5_real_exempt: assert (!flt);
      end
   end
endmodule

// File: rtl/dtr_image_pack.sv
module dtr_image_pack #(
   parameter int LIMIT_W   = 16,
   parameter int BASE_W    = 64,
   parameter int SHORT_W   = 32,
   parameter int BUS_BYTES = 16,
   localparam int BUS_W       = BUS_BYTES * 8,
   localparam int SHORT_BYTES = (LIMIT_W + SHORT_W) / 8,
   localparam int LONG_BYTES  = (LIMIT_W + BASE_W) / 8
) (
   input  logic                 wide,
   input  logic [LIMIT_W-1:0]   limit,
   input  logic [BASE_W-1:0]    base,
   output logic [BUS_W-1:0]     data,
   output logic [BUS_BYTES-1:0] be
);
   if (LONG_BYTES > BUS_BYTES) begin : g_bus_small
      $error("data bus too narrow for the long image");
   end
   if (SHORT_W > BASE_W || (LIMIT_W % 8) != 0 || (BASE_W % 8) != 0 || (SHORT_W % 8) != 0)
   begin : g_bad_fields
      $error("field widths must be whole bytes and short base within base");
   end

   always_comb begin
      data = '0;
      data[LIMIT_W-1:0] = limit;
      if (wide) data[LIMIT_W +: BASE_W]  = base;
      else      data[LIMIT_W +: SHORT_W] = base[SHORT_W-1:0];
   end

   for (genvar i = 0; i < BUS_BYTES; i++) begin : g_be
      localparam logic IN_SHORT = (i < SHORT_BYTES) ? 1'b1 : 1'b0;
      localparam logic IN_LONG  = (i < LONG_BYTES)  ? 1'b1 : 1'b0;
      assign be[i] = wide ? IN_LONG : IN_SHORT;
   end
endmodule

// File: rtl/dtr_store_unit.sv
module dtr_store_unit
   import dtr_store_pkg::*;
#(
   parameter int ADDR_W    = 64,
   parameter int LIMIT_W   = 16,
   parameter int BASE_W    = 64,
   parameter int BUS_BYTES = 16,
   localparam int BUS_W    = BUS_BYTES * 8,
   localparam int LO_W     = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [7:0]           opc_b0,
   input  logic [7:0]           opc_b1,
   input  logic [7:0]           modrm,
   input  logic                 lock_pfx,
   input  logic [1:0]           cpu_mode,
   input  logic [1:0]           cpl,
   input  logic                 umip_en,
   input  logic                 ac_en,
   input  logic [ADDR_W-1:0]    eff_addr,
   input  logic                 addr_canon,
   input  logic                 seg_lim_ok,
   input  logic                 seg_is_ss,
   input  logic                 seg_null,
   input  logic                 pg_fault,
   input  logic [LIMIT_W-1:0]   tbl_limit,
   input  logic [BASE_W-1:0]    tbl_base,
   output logic                 wr_valid,
   input  logic                 wr_ready,
   output logic [ADDR_W-1:0]    wr_addr,
   output logic [BUS_W-1:0]     wr_data,
   output logic [BUS_BYTES-1:0] wr_be,
   output logic                 done,
   output logic                 fault_valid,
   output logic [7:0]           fault_vec
);
   if (ADDR_W < LO_W) begin : g_addr_small
      $error("address narrower than alignment field");
   end

   cpu_mode_e            mode;
   store_st_e            state;
   logic                 hit;
   logic                 flt;
   logic [7:0]           vec;
   logic [BUS_W-1:0]     img_data;
   logic [BUS_BYTES-1:0] img_be;
   logic                 take;

   assign mode = cpu_mode_e'(cpu_mode);
   assign take = req_valid && hit && (state == ST_IDLE);

   dtr_decode u_decode (
      .opc_b0 (opc_b0),
      .opc_b1 (opc_b1),
      .modrm  (modrm),
      .hit    (hit)
   );

   dtr_fault_check #(
      .SHORT_ALIGN (2),
      .LONG_ALIGN  (8)
   ) u_fault (
      .mode       (mode),
      .cpl        (cpl),
      .umip_en    (umip_en),
      .ac_en      (ac_en),
      .lock_pfx   (lock_pfx),
      .addr_lo    (eff_addr[LO_W-1:0]),
      .addr_canon (addr_canon),
      .seg_lim_ok (seg_lim_ok),
      .seg_is_ss  (seg_is_ss),
      .seg_null   (seg_null),
      .pg_fault   (pg_fault),
      .flt        (flt),
      .vec        (vec)
   );

   dtr_image_pack #(
      .LIMIT_W   (LIMIT_W),
      .BASE_W    (BASE_W),
      .SHORT_W   (32),
      .BUS_BYTES (BUS_BYTES)
   ) u_pack (
      .wide  (mode == MODE_LONG),
      .limit (tbl_limit),
      .base  (tbl_base),
      .data  (img_data),
      .be    (img_be)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         wr_valid    <= 1'b0;
         wr_addr     <= '0;
         wr_data     <= '0;
         wr_be       <= '0;
         done        <= 1'b0;
         fault_valid <= 1'b0;
         fault_vec   <= 8'd0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (take) begin
                  if (flt) begin
                     state       <= ST_FLT;
                     fault_valid <= 1'b1;
                     fault_vec   <= vec;
                  end else begin
                     state    <= ST_WRITE;
                     wr_valid <= 1'b1;
                     wr_addr  <= eff_addr;
                     wr_data  <= img_data;
                     wr_be    <= img_be;
                  end
               end
            end
            ST_WRITE: begin
               if (wr_ready) begin
                  wr_valid <= 1'b0;
                  done     <= 1'b1;
                  state    <= ST_FIN;
               end
            end
            ST_FIN: begin
               done  <= 1'b0;
               state <= ST_IDLE;
            end
            default: begin
               fault_valid <= 1'b0;
               state       <= ST_IDLE;
            end
         endcase
      end
   end

   // R10: request held stable while not accepted
   a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be));

   // R10: done follows acceptance by one cycle
   a_r10_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && wr_ready |=> done && !wr_valid);

   // R10: fault never coincides with a write or completion
   a_r10_fault_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(fault_valid && (wr_valid || done)));

   // R4: LOCK gives #UD and no write
   a_r4_lock_ud: assert property (@(posedge clk) disable iff (!rst_n)
      take && lock_pfx |=> fault_valid && fault_vec == VEC_UD && !wr_valid);

   // R1: non-matching instruction leaves outputs quiet
   a_r1_ignore_other: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_IDLE && !(req_valid && hit) |=> !fault_valid && !wr_valid);

   // R2/R3: image size is one of the two forms
   a_r3_image_size: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> ($countones(wr_be) == 6 || $countones(wr_be) == 10));
endmodule

// File: tb/dtr_store_unit_tb.sv
module dtr_store_unit_tb;
   logic         clk = 1'b0;
   logic         rst_n;
   logic         req_valid;
   logic [7:0]   opc_b0, opc_b1, modrm;
   logic         lock_pfx;
   logic [1:0]   cpu_mode, cpl;
   logic         umip_en, ac_en;
   logic [63:0]  eff_addr;
   logic         addr_canon, seg_lim_ok, seg_is_ss, seg_null, pg_fault;
   logic [15:0]  tbl_limit;
   logic [63:0]  tbl_base;
   logic         wr_valid, wr_ready;
   logic [63:0]  wr_addr;
   logic [127:0] wr_data;
   logic [15:0]  wr_be;
   logic         done, fault_valid;
   logic [7:0]   fault_vec;

   int total = 0;
   int bad   = 0;

   localparam logic [7:0] E_UD = 8'd6, E_SS = 8'd12, E_GP = 8'd13, E_PF = 8'd14, E_AC = 8'd17;
   localparam logic [63:0]  BASE  = 64'h1122_3344_5566_7788;
   localparam logic [15:0]  LIM   = 16'h03FF;
   localparam logic [127:0] IMG6  = 128'h5566_7788_03FF;
   localparam logic [127:0] IMG10 = 128'h1122_3344_5566_7788_03FF;

   always #10 clk = ~clk;

   dtr_store_unit u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .opc_b0(opc_b0), .opc_b1(opc_b1), .modrm(modrm), .lock_pfx(lock_pfx),
      .cpu_mode(cpu_mode), .cpl(cpl), .umip_en(umip_en), .ac_en(ac_en),
      .eff_addr(eff_addr), .addr_canon(addr_canon), .seg_lim_ok(seg_lim_ok),
      .seg_is_ss(seg_is_ss), .seg_null(seg_null), .pg_fault(pg_fault),
      .tbl_limit(tbl_limit), .tbl_base(tbl_base),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_be(wr_be), .done(done),
      .fault_valid(fault_valid), .fault_vec(fault_vec)
   );

   task automatic chk(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic defaults();
      req_valid = 0; opc_b0 = 8'h0F; opc_b1 = 8'h01; modrm = 8'b00_001_000;
      lock_pfx = 0; cpu_mode = 2'd2; cpl = 2'd0; umip_en = 0; ac_en = 0;
      eff_addr = 64'h1000; addr_canon = 1; seg_lim_ok = 1; seg_is_ss = 0;
      seg_null = 0; pg_fault = 0; tbl_limit = LIM; tbl_base = BASE; wr_ready = 0;
   endtask

   task automatic fire();
      @(negedge clk) req_valid = 1;
      @(negedge clk) req_valid = 0;
   endtask

   task automatic expect_write(input logic [127:0] img, input logic [15:0] be, input string req);
      fire();
      chk(wr_valid && !fault_valid, req, {wr_valid, fault_valid}, 2'b10);
      chk(wr_addr == eff_addr, req, wr_addr, eff_addr);
      chk(wr_data == img, req, wr_data, img);
      chk(wr_be == be, req, wr_be, be);
      @(negedge clk);
      chk(wr_valid && wr_data == img && !done, "R10 hold", {wr_valid, done}, 2'b10);
      wr_ready = 1;
      @(negedge clk);
      wr_ready = 0;
      chk(done && !wr_valid, "R10 done", {done, wr_valid}, 2'b10);
      @(negedge clk);
      chk(!done && !wr_valid, "R10 done pulse", {done, wr_valid}, 2'b00);
   endtask

   task automatic expect_fault(input logic [7:0] v, input string req);
      fire();
      chk(fault_valid && fault_vec == v && !wr_valid, req, {fault_valid, wr_valid, fault_vec}, {2'b10, v});
      @(negedge clk);
      chk(!fault_valid && !wr_valid && !done, "R10 fault pulse", {fault_valid, wr_valid}, 2'b00);
   endtask

   task automatic expect_quiet(input string req);
      fire();
      chk(!fault_valid && !wr_valid, req, {fault_valid, wr_valid}, 2'b00);
      @(negedge clk);
      chk(!fault_valid && !wr_valid && !done, req, {fault_valid, wr_valid, done}, 3'b000);
   endtask

   task automatic t_reset();
      chk(!wr_valid && !done && !fault_valid && fault_vec == 0, "R12 reset",
          {wr_valid, done, fault_valid, fault_vec}, 0);
   endtask

   task automatic t_layouts();
      defaults(); expect_write(IMG6, 16'h003F, "R2 protected 6-byte");
      defaults(); cpu_mode = 2'd0; eff_addr = 64'h2001; expect_write(IMG6, 16'h003F, "R2 real 6-byte");
      defaults(); cpu_mode = 2'd3; eff_addr = 64'hFFFF_8000_0000_1008;
      expect_write(IMG10, 16'h03FF, "R3 64-bit 10-byte");
   endtask

   task automatic t_decode();
      defaults(); modrm = 8'b11_001_000; expect_quiet("R1 register form");
      defaults(); modrm = 8'b00_010_000; expect_quiet("R1 other reg field");
      defaults(); opc_b1 = 8'h00; expect_quiet("R1 other opcode");
      defaults(); modrm = 8'b10_001_100; expect_write(IMG6, 16'h003F, "R1 mod 10 taken");
   endtask

   task automatic t_lock();
      defaults(); lock_pfx = 1; cpu_mode = 2'd3; expect_fault(E_UD, "R4 lock 64-bit");
      defaults(); lock_pfx = 1; cpu_mode = 2'd0; expect_fault(E_UD, "R4 lock real");
   endtask

   task automatic t_umip();
      defaults(); umip_en = 1; cpl = 2'd1; expect_fault(E_GP, "R5 protected cpl1");
      defaults(); umip_en = 1; cpl = 2'd3; cpu_mode = 2'd3; expect_fault(E_GP, "R5 64-bit cpl3");
      defaults(); umip_en = 1; cpl = 2'd0; expect_write(IMG6, 16'h003F, "R5 protected cpl0");
      defaults(); umip_en = 1; cpu_mode = 2'd1; expect_fault(E_GP, "R5 v86 any cpl");
      defaults(); umip_en = 1; cpl = 2'd3; cpu_mode = 2'd0; expect_write(IMG6, 16'h003F, "R5 real exempt");
   endtask

   task automatic t_align();
      defaults(); ac_en = 1; cpl = 2'd3; eff_addr = 64'h1001; expect_fault(E_AC, "R6 protected odd cpl3");
      defaults(); ac_en = 1; cpl = 2'd2; eff_addr = 64'h1001; expect_write(IMG6, 16'h003F, "R6 cpl2 exempt");
      defaults(); ac_en = 1; cpl = 2'd3; eff_addr = 64'h1002; expect_write(IMG6, 16'h003F, "R6 short aligned");
      defaults(); ac_en = 1; cpl = 2'd3; cpu_mode = 2'd3; eff_addr = 64'h1004;
      expect_fault(E_AC, "R6 64-bit not 8-aligned");
      defaults(); ac_en = 1; cpl = 2'd0; cpu_mode = 2'd1; eff_addr = 64'h1003;
      expect_fault(E_AC, "R6 v86 any cpl");
      defaults(); ac_en = 1; cpl = 2'd3; cpu_mode = 2'd0; eff_addr = 64'h1003;
      expect_write(IMG6, 16'h003F, "R6 real exempt");
   endtask

   task automatic t_canon();
      defaults(); cpu_mode = 2'd3; addr_canon = 0; seg_is_ss = 1; expect_fault(E_SS, "R7 noncanonical ss");
      defaults(); cpu_mode = 2'd3; addr_canon = 0; expect_fault(E_GP, "R7 noncanonical other");
      defaults(); cpu_mode = 2'd3; seg_lim_ok = 0; seg_null = 1; eff_addr = 64'h1000;
      expect_write(IMG10, 16'h03FF, "R7 limit ignored in 64-bit");
   endtask

   task automatic t_segment();
      defaults(); seg_lim_ok = 0; seg_is_ss = 1; expect_fault(E_SS, "R8 limit ss");
      defaults(); seg_lim_ok = 0; expect_fault(E_GP, "R8 limit ds");
      defaults(); seg_null = 1; expect_fault(E_GP, "R8 null protected");
      defaults(); seg_null = 1; cpu_mode = 2'd1; expect_write(IMG6, 16'h003F, "R8 null v86 ignored");
      defaults(); seg_lim_ok = 0; cpu_mode = 2'd0; expect_fault(E_GP, "R8 limit real");
   endtask

   task automatic t_priority();
      defaults(); lock_pfx = 1; umip_en = 1; cpl = 2'd3; seg_lim_ok = 0; seg_is_ss = 1;
      expect_fault(E_UD, "R9 lock over all");
      defaults(); umip_en = 1; cpl = 2'd3; seg_lim_ok = 0; seg_is_ss = 1;
      expect_fault(E_GP, "R9 umip over segment");
      defaults(); seg_lim_ok = 0; seg_is_ss = 1; ac_en = 1; cpl = 2'd3; eff_addr = 64'h1001;
      expect_fault(E_SS, "R9 segment over align");
      defaults(); ac_en = 1; cpl = 2'd3; eff_addr = 64'h1001; pg_fault = 1;
      expect_fault(E_AC, "R9 align over page fault");
   endtask

   task automatic t_pagefault();
      defaults(); pg_fault = 1; expect_fault(E_PF, "R11 protected");
      defaults(); pg_fault = 1; cpu_mode = 2'd3; expect_fault(E_PF, "R11 64-bit");
      defaults(); pg_fault = 1; cpu_mode = 2'd0; expect_write(IMG6, 16'h003F, "R11 real ignored");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      defaults();
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_layouts();
      t_decode();
      t_lock();
      t_umip();
      t_align();
      t_canon();
      t_segment();
      t_priority();
      t_pagefault();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule